// File: doc/BRIEF.md
# SMBus Host Controller Register Front End

This block is the byte-wide register side of an SMBus host controller. It sits in a 64-byte I/O window. Software sets up a target address with a direction bit, a command byte, two data bytes and, for block transfers, a buffer of bytes. A write to the control register with the start bit set then launches one transaction. The block does not drive the SMBus wires. It hands each transaction to a separate bus engine through a level request that stays high until the engine pulses done. All transaction fields are captured at launch and held steady on the request outputs.

When a read-direction transfer completes, the engine's returned bytes are loaded into the data registers. For block reads the engine fills the shared 32-entry buffer through its own port. Software reaches that buffer through a single data port with a self-advancing index. The index wraps after the last entry. It is rewound by any status write or by reading the control register.

Top module: `smb_host_regs`

## Requirements
- R1: After reset the status, control, command, address and data registers read 0 and `eng_req` is low.
- R2: Offsets 0x03 (command), 0x04 (address), 0x05 (data 0) and 0x06 (data 1) read back the last byte written. Offsets with no register (such as 0x01 and 0x3F) read 0. `reg_rdata` is valid in the cycle after the `reg_rd` strobe.
- R3: A write to offset 0x02 with bit 6 set, while no request is outstanding and with a supported protocol code in bits 4:2, raises `eng_req` on the next cycle. The outputs then carry `eng_proto` = bits 4:2, `eng_addr` = address register bits 7:1, `eng_read` = address register bit 0 (1 = read), and the command, data 0 and data 1 values. Status bit 0 (busy) reads 1 while the request is outstanding.
- R4: The supported protocol codes are 0 quick, 1 byte, 2 byte-data, 3 word and 5 block. A start with code 4, 6 or 7 sets status bit 2 (error) and raises no request.
- R5: `eng_req` stays high until `eng_done` is seen high. On the next cycle it falls, busy clears and status bit 1 (done) is set.
- R6: On completion of a read-direction transfer, codes 1 and 2 load data 0 from `eng_rdata0`. Code 3 loads data 0 with the low byte and data 1 with the high byte. Code 5 loads the returned byte count into data 0. Quick transfers and write-direction transfers leave data 0 and data 1 unchanged.
- R7: Any write to offset 0x00 clears the done and error bits and sets the block index to 0.
- R8: Each read or write of offset 0x07 accesses buffer[index] and then increments the index. The index wraps from 31 to 0.
- R9: Reading offset 0x02 returns only the low 5 bits of the control register and sets the block index to 0.
- R10: The engine port reads the buffer with one cycle of latency, and its writes are visible through offset 0x07.
- R11: A start written while a request is outstanding is ignored, and the request fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Byte offset in the window |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, one cycle after `reg_rd` |
| eng_req | output | 1 | Transaction request, held until done |
| eng_proto | output | 3 | Protocol code |
| eng_addr | output | 7 | Target address |
| eng_read | output | 1 | 1 = read direction |
| eng_cmd | output | 8 | Command byte |
| eng_data0 | output | 8 | Data 0 (low byte / block length) |
| eng_data1 | output | 8 | Data 1 (high byte) |
| eng_done | input | 1 | Engine completion pulse |
| eng_rdata0 | input | 8 | Returned low byte or block count |
| eng_rdata1 | input | 8 | Returned high byte |
| eng_buf_addr | input | 5 | Engine buffer index |
| eng_buf_we | input | 1 | Engine buffer write enable |
| eng_buf_wdata | input | 8 | Engine buffer write data |
| eng_buf_rdata | output | 8 | Engine buffer read data, one cycle latency |

## Verification
Two situations are hard to reach from the ports. The first is the index wrap, which needs a full pass of 33 port writes so that the 33rd write lands back on entry 0. The second is a start attempted while a request is still outstanding. The bench reaches the wrap with that long write run. It then rewinds with a status write and confirms both entry 0 and entry 31, the latter through the engine port. For the busy case it holds back the engine's done pulse, rewrites the command and the control register, and checks that the request outputs keep their launch values.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;
  localparam int WIN_AW = 6;
  localparam int DW     = 8;

  localparam logic [WIN_AW-1:0] OFS_STAT = 6'h00;
  localparam logic [WIN_AW-1:0] OFS_CTL  = 6'h02;
  localparam logic [WIN_AW-1:0] OFS_CMD  = 6'h03;
  localparam logic [WIN_AW-1:0] OFS_ADR  = 6'h04;
  localparam logic [WIN_AW-1:0] OFS_D0   = 6'h05;
  localparam logic [WIN_AW-1:0] OFS_D1   = 6'h06;
  localparam logic [WIN_AW-1:0] OFS_BLK  = 6'h07;

  localparam logic [2:0] PR_QUICK = 3'd0;
  localparam logic [2:0] PR_BYTE  = 3'd1;
  localparam logic [2:0] PR_BDATA = 3'd2;
  localparam logic [2:0] PR_WORD  = 3'd3;
  localparam logic [2:0] PR_BLOCK = 3'd5;

  localparam int CTL_START = 6;

  function automatic logic proto_ok(input logic [2:0] p);
    return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
           (p == PR_WORD) || (p == PR_BLOCK);
  endfunction
endpackage

// File: rtl/smb_blk_ram.sv
module smb_blk_ram #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [W-1:0]  b_wdata,
  output logic [W-1:0]  b_rdata
);
  logic [W-1:0] mem [DEPTH];

  // Single write process; host port takes precedence on a same-entry clash.
  always_ff @(posedge clk) begin
    if (b_we) mem[b_addr] <= b_wdata;
    if (a_en && a_we) mem[a_addr] <= a_wdata;
  end

  always_ff @(posedge clk) begin
    if (a_en && !a_we) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/smb_blk_index.sv
module smb_blk_index #(
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst || clr)  idx <= '0;
    else if (step)   idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  // R8: the index returns to 0 after the last entry
  p_idx_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (step && !clr && idx == LAST) |=> (idx == '0));

  // R7 / R9: a rewind request always lands on entry 0
  p_idx_clr_r7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (idx == '0));
endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
  import smb_host_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int IDX_W     = $clog2(BUF_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIN_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              eng_req,
  output logic [2:0]        eng_proto,
  output logic [6:0]        eng_addr,
  output logic              eng_read,
  output logic [DW-1:0]     eng_cmd,
  output logic [DW-1:0]     eng_data0,
  output logic [DW-1:0]     eng_data1,
  input  logic              eng_done,
  input  logic [DW-1:0]     eng_rdata0,
  input  logic [DW-1:0]     eng_rdata1,
  input  logic [IDX_W-1:0]  eng_buf_addr,
  input  logic              eng_buf_we,
  input  logic [DW-1:0]     eng_buf_wdata,
  output logic [DW-1:0]     eng_buf_rdata
);
  logic          st_done, st_err;
  logic [4:0]    ctl_q;
  logic [DW-1:0] cmd_q, adr_q, d0_q, d1_q;
  logic [DW-1:0] misc_q, ram_q;
  logic          from_ram_q;
  logic [IDX_W-1:0] blk_idx;

  logic hit_blk, idx_clr, idx_step, start_wr, finish;
  assign hit_blk  = (reg_addr == OFS_BLK);
  assign idx_clr  = (reg_wr && reg_addr == OFS_STAT) || (reg_rd && reg_addr == OFS_CTL);
  assign idx_step = (reg_wr || reg_rd) && hit_blk;
  assign start_wr = reg_wr && reg_addr == OFS_CTL && reg_wdata[CTL_START];
  assign finish   = eng_req && eng_done;

  smb_blk_index #(.DEPTH(BUF_DEPTH), .AW(IDX_W)) u_index (
    .clk(clk), .rst(rst), .clr(idx_clr), .step(idx_step), .idx(blk_idx)
  );

  smb_blk_ram #(.DEPTH(BUF_DEPTH), .W(DW), .AW(IDX_W)) u_buf (
    .clk(clk),
    .a_en(idx_step), .a_we(reg_wr), .a_addr(blk_idx),
    .a_wdata(reg_wdata), .a_rdata(ram_q),
    .b_we(eng_buf_we), .b_addr(eng_buf_addr),
    .b_wdata(eng_buf_wdata), .b_rdata(eng_buf_rdata)
  );

  // Register file, launch and completion
  always_ff @(posedge clk) begin
    if (rst) begin
      st_done <= 1'b0; st_err <= 1'b0; ctl_q <= '0;
      cmd_q <= '0; adr_q <= '0; d0_q <= '0; d1_q <= '0;
      eng_req <= 1'b0; eng_proto <= '0; eng_addr <= '0; eng_read <= 1'b0;
      eng_cmd <= '0; eng_data0 <= '0; eng_data1 <= '0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          OFS_STAT: begin st_done <= 1'b0; st_err <= 1'b0; end
          OFS_CTL:  ctl_q <= reg_wdata[4:0];
          OFS_CMD:  cmd_q <= reg_wdata;
          OFS_ADR:  adr_q <= reg_wdata;
          OFS_D0:   d0_q  <= reg_wdata;
          OFS_D1:   d1_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (start_wr && !eng_req) begin
        if (proto_ok(reg_wdata[4:2])) begin
          eng_req   <= 1'b1;
          eng_proto <= reg_wdata[4:2];
          eng_addr  <= adr_q[7:1];
          eng_read  <= adr_q[0];
          eng_cmd   <= cmd_q;
          eng_data0 <= d0_q;
          eng_data1 <= d1_q;
        end else begin
          st_err <= 1'b1;
        end
      end
      if (finish) begin
        eng_req <= 1'b0;
        st_done <= 1'b1;
        if (eng_read) begin
          case (eng_proto)
            PR_BYTE, PR_BDATA, PR_BLOCK: d0_q <= eng_rdata0;
            PR_WORD: begin d0_q <= eng_rdata0; d1_q <= eng_rdata1; end
            default: ;
          endcase
        end
      end
    end
  end

  // Registered readback
  always_ff @(posedge clk) begin
    if (rst) begin
      misc_q <= '0; from_ram_q <= 1'b0;
    end else if (reg_rd) begin
      from_ram_q <= hit_blk;
      case (reg_addr)
        OFS_STAT: misc_q <= {5'b0, st_err, st_done, eng_req};
        OFS_CTL:  misc_q <= {3'b0, ctl_q};
        OFS_CMD:  misc_q <= cmd_q;
        OFS_ADR:  misc_q <= adr_q;
        OFS_D0:   misc_q <= d0_q;
        OFS_D1:   misc_q <= d1_q;
        default:  misc_q <= '0;
      endcase
    end
  end

  assign reg_rdata = from_ram_q ? ram_q : misc_q;

  // R3: a good start raises the request with the written protocol
  p_start_launch_r3: assert property (@(posedge clk) disable iff (rst)
    (start_wr && !eng_req && proto_ok(reg_wdata[4:2]))
      |=> (eng_req && eng_proto == $past(reg_wdata[4:2])));

  // R4: an unsupported code flags an error and does not request
  p_bad_proto_r4: assert property (@(posedge clk) disable iff (rst)
    (start_wr && !eng_req && !proto_ok(reg_wdata[4:2])) |=> (!eng_req && st_err));

  // R5: the request is held until the engine answers
  p_req_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> eng_req);

  // R5: completion drops the request and marks done
  p_finish_r5: assert property (@(posedge clk) disable iff (rst)
    (eng_req && eng_done) |=> (!eng_req && st_done));

  // R11: fields stay put while the request is outstanding
  p_busy_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (eng_req && !eng_done) |=> ($stable(eng_cmd) && $stable(eng_proto) && $stable(eng_addr)));

  // R9: a control read rewinds the block index
  p_ctl_rewind_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == OFS_CTL) |=> (blk_idx == '0));
endmodule

// File: tb/test_smb_host_regs.sv
`timescale 1ns/100ps
module test_smb_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       eng_req, eng_read;
  logic [2:0] eng_proto;
  logic [6:0] eng_addr;
  logic [7:0] eng_cmd, eng_data0, eng_data1;
  logic       eng_done = 1'b0;
  logic [7:0] eng_rdata0 = '0, eng_rdata1 = '0;
  logic [4:0] eng_buf_addr = '0;
  logic       eng_buf_we = 1'b0;
  logic [7:0] eng_buf_wdata = '0;
  logic [7:0] eng_buf_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  smb_host_regs i_smb_host_regs (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .eng_req(eng_req),
    .eng_proto(eng_proto), .eng_addr(eng_addr), .eng_read(eng_read),
    .eng_cmd(eng_cmd), .eng_data0(eng_data0), .eng_data1(eng_data1),
    .eng_done(eng_done), .eng_rdata0(eng_rdata0), .eng_rdata1(eng_rdata1),
    .eng_buf_addr(eng_buf_addr), .eng_buf_we(eng_buf_we),
    .eng_buf_wdata(eng_buf_wdata), .eng_buf_rdata(eng_buf_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic eng_finish(input logic [7:0] r0, input logic [7:0] r1);
    @(negedge clk); eng_done = 1'b1; eng_rdata0 = r0; eng_rdata1 = r1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic eng_wbuf(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); eng_buf_addr = a; eng_buf_wdata = d; eng_buf_we = 1'b1;
    @(negedge clk); eng_buf_we = 1'b0;
  endtask

  task automatic eng_rbuf_chk(input string req, input logic [4:0] a, input logic [7:0] exp);
    @(negedge clk); eng_buf_addr = a;
    @(negedge clk); chk(req, eng_buf_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 eng_req", eng_req, 0);
    rd_chk("R1 status", 6'h00, 8'h00);
    rd_chk("R1 control", 6'h02, 8'h00);
    rd_chk("R1 data0", 6'h05, 8'h00);
  endtask

  task automatic t_regs;
    wr(6'h03, 8'hA5); wr(6'h04, 8'h3C); wr(6'h05, 8'h11); wr(6'h06, 8'h22);
    rd_chk("R2 cmd", 6'h03, 8'hA5);
    rd_chk("R2 addr", 6'h04, 8'h3C);
    rd_chk("R2 data0", 6'h05, 8'h11);
    rd_chk("R2 data1", 6'h06, 8'h22);
    rd_chk("R2 gap 0x01", 6'h01, 8'h00);
    rd_chk("R2 gap 0x3F", 6'h3F, 8'h00);
  endtask

  task automatic t_word_write;
    wr(6'h04, 8'hA0); wr(6'h03, 8'h12); wr(6'h05, 8'h34); wr(6'h06, 8'h56);
    wr(6'h02, 8'h4C);
    chk("R3 req", eng_req, 1);
    chk("R3 proto", eng_proto, 3);
    chk("R3 addr", eng_addr, 7'h50);
    chk("R3 dir", eng_read, 0);
    chk("R3 cmd", eng_cmd, 8'h12);
    chk("R3 data", {eng_data1, eng_data0}, 16'h5634);
    rd_chk("R3 busy", 6'h00, 8'h01);
    wr(6'h03, 8'h99); wr(6'h02, 8'h44);
    chk("R11 cmd held", eng_cmd, 8'h12);
    chk("R11 proto held", eng_proto, 3);
    eng_finish(8'hEE, 8'hDD);
    chk("R5 req drop", eng_req, 0);
    rd_chk("R6 write keeps data0", 6'h05, 8'h34);
    rd_chk("R5 done", 6'h00, 8'h02);
  endtask

  task automatic t_word_read;
    wr(6'h00, 8'h00);
    rd_chk("R7 status clear", 6'h00, 8'h00);
    wr(6'h04, 8'hA1); wr(6'h02, 8'h4C);
    chk("R3 read dir", eng_read, 1);
    chk("R3 read addr", eng_addr, 7'h50);
    eng_finish(8'h78, 8'h9A);
    rd_chk("R6 word low", 6'h05, 8'h78);
    rd_chk("R6 word high", 6'h06, 8'h9A);
    wr(6'h00, 8'hFF);
  endtask

  task automatic t_bad_proto;
    wr(6'h02, 8'h50);
    chk("R4 code4 no req", eng_req, 0);
    rd_chk("R4 code4 err", 6'h00, 8'h04);
    wr(6'h00, 8'h00);
    wr(6'h02, 8'h5C);
    chk("R4 code7 no req", eng_req, 0);
    rd_chk("R4 code7 err", 6'h00, 8'h04);
    wr(6'h00, 8'h00);
    rd_chk("R7 err cleared", 6'h00, 8'h00);
  endtask

  task automatic t_block_port;
    wr(6'h00, 8'h00);
    wr(6'h07, 8'h10); wr(6'h07, 8'h11); wr(6'h07, 8'h12);
    eng_rbuf_chk("R10 buf0", 5'd0, 8'h10);
    eng_rbuf_chk("R8 buf2", 5'd2, 8'h12);
    rd_chk("R9 ctl low bits", 6'h02, 8'h1C);
    rd_chk("R9 rewound", 6'h07, 8'h10);
    rd_chk("R8 advance", 6'h07, 8'h11);
  endtask

  task automatic t_wrap;
    wr(6'h00, 8'h00);
    for (int i = 0; i < 33; i++) wr(6'h07, 8'(8'h80 + i));
    wr(6'h00, 8'h00);
    rd_chk("R8 wrap entry0", 6'h07, 8'hA0);
    rd_chk("R8 wrap entry1", 6'h07, 8'h81);
    eng_rbuf_chk("R8 entry31", 5'd31, 8'h9F);
  endtask

  task automatic t_block_read;
    wr(6'h00, 8'h00);
    wr(6'h05, 8'h05); wr(6'h04, 8'h21); wr(6'h02, 8'h54);
    chk("R3 block proto", eng_proto, 5);
    chk("R3 block len", eng_data0, 8'h05);
    eng_wbuf(5'd0, 8'hC0); eng_wbuf(5'd1, 8'hC1);
    eng_finish(8'h02, 8'h00);
    rd_chk("R6 block count", 6'h05, 8'h02);
    rd_chk("R9 ctl", 6'h02, 8'h14);
    rd_chk("R10 block byte0", 6'h07, 8'hC0);
    rd_chk("R10 block byte1", 6'h07, 8'hC1);
  endtask

  task automatic t_quick;
    wr(6'h00, 8'h00);
    wr(6'h05, 8'h33); wr(6'h04, 8'h21); wr(6'h02, 8'h40);
    chk("R3 quick proto", eng_proto, 0);
    chk("R3 quick req", eng_req, 1);
    eng_finish(8'h77, 8'h66);
    rd_chk("R6 quick keeps data0", 6'h05, 8'h33);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_word_write();
    t_word_read();
    t_bad_proto();
    t_block_port();
    t_wrap();
    t_block_read();
    t_quick();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule